// File: doc/BRIEF.md
# Hibernation and Real-Time Clock Controller

This block lives in the always-on domain and runs from a 32.768 kHz clock. It keeps time in two counters: a 15-bit subsecond count and a 32-bit seconds count. It holds a seconds match value and sixteen 32-bit words that keep their contents for as long as the battery supply is good. It also decides when the main domain is powered down and when it is brought back.

Hibernation starts in one of two ways. Software can pulse a request. Alternatively, the main supply can fail while the battery is still good, provided that entry path is enabled. An optional guard refuses entry while the selected low-battery level is active. Three sources bring the device out of hibernation: the wake pin, a seconds match, and a low-battery condition when waking on it is enabled. On wake the hibernate indication drops. A reset pulse of fixed length is then sent to the main domain. Three sticky interrupt flags record match, pin and low-battery events.

Top module: `hib_rtc_ctrl`

## Requirements
- R1: After reset, `hib`, `por`, `int_flags`, `rtc_sec` and `rtc_sub` are all zero.
- R2: `rtc_sub` increases by one every clock. When it goes from 32767 to 0, `rtc_sec` increases by one. A `rtc_load` cycle instead loads both counters from the load inputs.
- R3: In the running state, `hib_req` high at a clock edge makes `hib` high from that edge. `hib` then stays high until a wake source acts.
- R4: With `cfg_loss_en` high, `vdd_ok` low while `bat_ok` is high enters hibernation in the same way. With `cfg_loss_en` low, that condition has no effect.
- R5: With `cfg_lowbat_block` high and the selected low-battery level active, an entry request is refused and `hib` stays low.
- R6: The selected low-battery level is `lowbat_lvl[cfg_bat_sel]`. The other three bits have no effect.
- R7: While hibernating, each of these wakes the device: `wake_pin` high; `rtc_sec` equal to the stored match value; or the selected low-battery level active while `cfg_lowbat_wake` is high. A low-battery level with `cfg_lowbat_wake` low does not wake it.
- R8: On wake, `hib` falls and `por` rises at the same edge. `por` stays high for exactly POR_CYCLES clocks (8 by default). `hib` and `por` are never high together.
- R9: The bits of `int_flags` are: bit 0 for seconds match, bit 1 for wake pin, bit 2 for selected low battery. Each bit is set by its event in any state and stays set until a 1 is written to the same bit of `int_clr`. If a set and a clear land in the same cycle, the set wins.
- R10: The retained words are written through `mem_we`/`mem_addr`/`mem_wdata` and read combinationally on `mem_rdata`. They keep their contents through hibernation. All words are cleared at the edge where `bat_ok` is sampled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on 32.768 kHz clock |
| rst_n | input | 1 | Active-low reset of the always-on domain |
| hib_req | input | 1 | Software request to hibernate |
| vdd_ok | input | 1 | Main supply valid |
| bat_ok | input | 1 | Battery supply valid |
| wake_pin | input | 1 | External wake input, active high |
| lowbat_lvl | input | 4 | Comparator result for each of the four thresholds |
| cfg_loss_en | input | 1 | Enable entry on main-supply loss |
| cfg_lowbat_block | input | 1 | Refuse entry on low battery |
| cfg_lowbat_wake | input | 1 | Wake on low battery |
| cfg_bat_sel | input | 2 | Threshold select |
| rtc_load | input | 1 | Load both time counters |
| rtc_load_sec | input | SEC_W | Seconds load value |
| rtc_load_sub | input | SUB_W | Subsecond load value |
| match_we | input | 1 | Write the match value |
| match_val | input | SEC_W | Match value |
| mem_we | input | 1 | Retained word write strobe |
| mem_addr | input | ADDR_W | Retained word address |
| mem_wdata | input | DATA_W | Retained word write data |
| int_clr | input | 3 | Write-1-to-clear for the flags |
| hib | output | 1 | Hibernating |
| por | output | 1 | Reset pulse to the main domain |
| int_flags | output | 3 | Sticky flags: match, pin, low battery |
| rtc_sec | output | SEC_W | Seconds count |
| rtc_sub | output | SUB_W | Subsecond count |
| mem_rdata | output | DATA_W | Retained word read data |

## Verification
A corrupted state register would show on `hib` or `por` at the very next edge. Examples are a missed wake, an entry that was not refused, or a reset pulse one clock too short or too long. The bench counts the pulse clock by clock. A subsecond counter that rolls over wrongly shows as a wrong `rtc_sec` at the edge after the rollover, which the bench provokes by loading values near the limit. Flag and retained-word faults show on the following clock's `int_flags` or `mem_rdata`. They are checked after set, clear, same-cycle collision, hibernation and battery loss.

// File: rtl/hib_rtc_ctrl.sv
module hib_rtc_ctrl #(
  parameter int SEC_W      = 32,
  parameter int SUB_W      = 15,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int POR_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hib_req,
  input  logic              vdd_ok,
  input  logic              bat_ok,
  input  logic              wake_pin,
  input  logic [3:0]        lowbat_lvl,
  input  logic              cfg_loss_en,
  input  logic              cfg_lowbat_block,
  input  logic              cfg_lowbat_wake,
  input  logic [1:0]        cfg_bat_sel,
  input  logic              rtc_load,
  input  logic [SEC_W-1:0]  rtc_load_sec,
  input  logic [SUB_W-1:0]  rtc_load_sub,
  input  logic              match_we,
  input  logic [SEC_W-1:0]  match_val,
  input  logic              mem_we,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_wdata,
  input  logic [2:0]        int_clr,
  output logic              hib,
  output logic              por,
  output logic [2:0]        int_flags,
  output logic [SEC_W-1:0]  rtc_sec,
  output logic [SUB_W-1:0]  rtc_sub,
  output logic [DATA_W-1:0] mem_rdata
);
  localparam int WORDS = 1 << ADDR_W;
  localparam int CW    = $clog2(POR_CYCLES + 1);

  typedef enum logic [1:0] {S_RUN, S_HIB, S_POR} st_t;

  st_t               st;
  logic [CW-1:0]     por_cnt;
  logic [SEC_W-1:0]  match_q;
  logic [DATA_W-1:0] words [WORDS];

  wire lowbat    = lowbat_lvl[cfg_bat_sel];
  wire match_hit = (rtc_sec == match_q);
  wire enter     = (hib_req | (cfg_loss_en & ~vdd_ok & bat_ok)) & ~(cfg_lowbat_block & lowbat);
  wire wake      = wake_pin | match_hit | (cfg_lowbat_wake & lowbat);

  assign hib       = (st == S_HIB);
  assign por       = (st == S_POR);
  assign mem_rdata = words[mem_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_RUN;
      por_cnt <= '0;
    end else begin
      case (st)
        S_RUN: if (enter) st <= S_HIB;
        S_HIB: if (wake) begin
          st      <= S_POR;
          por_cnt <= CW'(POR_CYCLES - 1);
        end
        S_POR: if (por_cnt == '0) st <= S_RUN;
               else por_cnt <= por_cnt - 1'b1;
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rtc_sec <= '0;
      rtc_sub <= '0;
    end else if (rtc_load) begin
      rtc_sec <= rtc_load_sec;
      rtc_sub <= rtc_load_sub;
    end else begin
      rtc_sub <= rtc_sub + 1'b1;
      if (&rtc_sub) rtc_sec <= rtc_sec + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q   <= '1;
      int_flags <= '0;
    end else begin
      if (match_we) match_q <= match_val;
      int_flags <= (int_flags & ~int_clr) | {lowbat, wake_pin, match_hit};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else if (!bat_ok) begin
      for (int i = 0; i < WORDS; i++) words[i] <= '0;
    end else if (mem_we) begin
      words[mem_addr] <= mem_wdata;
    end
  end
endmodule

// File: rtl/hib_rtc_ctrl_chk.sv
module hib_rtc_ctrl_chk #(
  parameter int SEC_W  = 32,
  parameter int SUB_W  = 15,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hib_req,
  input logic              vdd_ok,
  input logic              bat_ok,
  input logic              wake_pin,
  input logic [3:0]        lowbat_lvl,
  input logic              cfg_loss_en,
  input logic              cfg_lowbat_block,
  input logic [1:0]        cfg_bat_sel,
  input logic              rtc_load,
  input logic [2:0]        int_clr,
  input logic              hib,
  input logic              por,
  input logic [2:0]        int_flags,
  input logic [SEC_W-1:0]  rtc_sec,
  input logic [SUB_W-1:0]  rtc_sub,
  input logic [DATA_W-1:0] mem_rdata
);
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hib && por));

  assert_wake_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hib) |-> por);

  // covers R4 as well
  assert_entry_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hib) |-> $past(hib_req || (cfg_loss_en && !vdd_ok && bat_ok)));

  assert_lowbat_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!hib && !por && cfg_lowbat_block && lowbat_lvl[cfg_bat_sel]) |=> !hib);

  assert_sub_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&rtc_sub && !rtc_load) |=> (rtc_sub == '0 && rtc_sec == $past(rtc_sec) + 1'b1));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((int_flags & ~int_clr) != 3'b000) |=>
      ((int_flags & $past(int_flags & ~int_clr)) == $past(int_flags & ~int_clr)));

  assert_mem_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bat_ok |=> (mem_rdata == '0));
endmodule

bind hib_rtc_ctrl hib_rtc_ctrl_chk #(.SEC_W(SEC_W), .SUB_W(SUB_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/hib_rtc_ctrl_test.sv
`timescale 1ns/100ps
module hib_rtc_ctrl_test;
  logic clk = 0, rst_n = 0;
  logic hib_req = 0, vdd_ok = 1, bat_ok = 1, wake_pin = 0;
  logic [3:0] lowbat_lvl = 0;
  logic cfg_loss_en = 0, cfg_lowbat_block = 0, cfg_lowbat_wake = 0;
  logic [1:0] cfg_bat_sel = 0;
  logic rtc_load = 0;
  logic [31:0] rtc_load_sec = 0;
  logic [14:0] rtc_load_sub = 0;
  logic match_we = 0;
  logic [31:0] match_val = 0;
  logic mem_we = 0;
  logic [3:0] mem_addr = 0;
  logic [31:0] mem_wdata = 0;
  logic [2:0] int_clr = 0;
  logic hib, por;
  logic [2:0] int_flags;
  logic [31:0] rtc_sec, mem_rdata;
  logic [14:0] rtc_sub;

  int checks = 0, errors = 0;
  bit finished = 0;
  string req_q[$];
  int sel_q[$];
  logic [31:0] exp_q[$];

  always #2.5 clk = ~clk;

  hib_rtc_ctrl uut (.*);

  function automatic logic [31:0] probe(int sel);
    case (sel)
      0: return {31'd0, hib};
      1: return {31'd0, por};
      2: return {29'd0, int_flags};
      3: return rtc_sec;
      4: return {17'd0, rtc_sub};
      default: return mem_rdata;
    endcase
  endfunction

  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      string r;
      int s;
      logic [31:0] e, a;
      r = req_q.pop_front(); s = sel_q.pop_front(); e = exp_q.pop_front();
      a = probe(s);
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s sel=%0d actual=%0h expected=%0h", r, s, a, e);
      end
    end
  end

  task automatic expect_val(string r, int sel, logic [31:0] e);
    req_q.push_back(r); sel_q.push_back(sel); exp_q.push_back(e);
  endtask

  task automatic step();
    wait (exp_q.size() == 0);
    @(posedge clk); #1;
  endtask

  task automatic por_window(string r);
    for (int i = 1; i < 8; i++) begin step(); expect_val(r, 1, 1); end
    step(); expect_val(r, 1, 0); expect_val(r, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step();
    expect_val("R1", 0, 0); expect_val("R1", 1, 0); expect_val("R1", 2, 0);
    expect_val("R1", 3, 0); expect_val("R1", 4, 0);
    step();
    rst_n = 1;

    // R2 rollover
    rtc_load = 1; rtc_load_sec = 5; rtc_load_sub = 15'd32766;
    step(); rtc_load = 0;
    expect_val("R2", 4, 32766); expect_val("R2", 3, 5);
    step(); expect_val("R2", 4, 32767); expect_val("R2", 3, 5);
    step(); expect_val("R2", 4, 0); expect_val("R2", 3, 6);
    step(); expect_val("R2", 4, 1);

    // R10 write/read
    mem_we = 1; mem_addr = 3; mem_wdata = 32'hA5A5_0003;
    step(); mem_we = 0;
    expect_val("R10", 5, 32'hA5A5_0003);

    // R9 flags
    wake_pin = 1; step(); wake_pin = 0;
    expect_val("R9", 2, 3'b010); expect_val("R9", 0, 0);
    step(); expect_val("R9", 2, 3'b010);
    int_clr = 3'b010; step(); int_clr = 0;
    expect_val("R9", 2, 3'b000);
    wake_pin = 1; int_clr = 3'b010; step(); wake_pin = 0; int_clr = 0;
    expect_val("R9", 2, 3'b010);
    match_we = 1; match_val = 6; step(); match_we = 0;
    step(); expect_val("R9", 2, 3'b011);
    match_we = 1; match_val = 1000; step(); match_we = 0;
    int_clr = 3'b111; step(); int_clr = 0;
    expect_val("R9", 2, 3'b000);

    // R3 entry, R7 pin wake, R8 pulse
    hib_req = 1; step(); hib_req = 0;
    expect_val("R3", 0, 1); expect_val("R3", 1, 0);
    step(); step(); expect_val("R3", 0, 1);
    expect_val("R10", 5, 32'hA5A5_0003);
    wake_pin = 1; step(); wake_pin = 0;
    expect_val("R7", 0, 0); expect_val("R8", 1, 1);
    por_window("R8");
    int_clr = 3'b111; step(); int_clr = 0;

    // R5 block, R6 select
    cfg_lowbat_block = 1; cfg_bat_sel = 2; lowbat_lvl = 4'b0100;
    hib_req = 1; step();
    expect_val("R5", 0, 0);
    step(); expect_val("R5", 0, 0); expect_val("R9", 2, 3'b100);
    lowbat_lvl = 4'b1011; step(); hib_req = 0;
    expect_val("R6", 0, 1);
    cfg_lowbat_block = 0;

    // R7 low-battery wake gated by enable
    lowbat_lvl = 4'b0100; step(); step();
    expect_val("R7", 0, 1);
    cfg_lowbat_wake = 1; step();
    expect_val("R7", 0, 0); expect_val("R8", 1, 1);
    lowbat_lvl = 0; cfg_lowbat_wake = 0;
    por_window("R8");

    // R7 match wake
    hib_req = 1; step(); hib_req = 0;
    expect_val("R3", 0, 1);
    rtc_load = 1; rtc_load_sec = 100; rtc_load_sub = 0; step(); rtc_load = 0;
    expect_val("R2", 3, 100);
    match_we = 1; match_val = 100; step(); match_we = 0;
    expect_val("R7", 0, 1);
    step(); expect_val("R7", 0, 0); expect_val("R8", 1, 1);
    por_window("R8");
    match_we = 1; match_val = 32'hFFFF_0000; step(); match_we = 0;

    // R4 supply loss entry
    vdd_ok = 0; step(); step();
    expect_val("R4", 0, 0);
    cfg_loss_en = 1; step();
    expect_val("R4", 0, 1);
    cfg_loss_en = 0; vdd_ok = 1;
    wake_pin = 1; step(); wake_pin = 0;
    expect_val("R8", 1, 1);
    por_window("R8");

    // R10 battery loss
    expect_val("R10", 5, 32'hA5A5_0003);
    bat_ok = 0; step(); bat_ok = 1;
    expect_val("R10", 5, 0);
    step();
    wait (exp_q.size() == 0);
    #3;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule